// File: doc/BRIEF.md
# Initiator Read Parity-Error Responder

This block watches the data phases of reads that the local bus initiator has started on a PCI or PCI-X bus. It covers only phases where the target hands back data immediately. Reads that end in a retry or a split response never raise the data-valid strobe, so they are never checked. For each valid phase it computes even parity over the address/data lanes and the byte enables. It compares that result with the parity bit the bus presents one clock later. A mismatch counts as a detected data parity error.

On a detected error, the block schedules an active-low PERR# pulse. The pulse comes two clocks after the failing phase in conventional mode and three clocks after it in PCI-X mode, and only if parity-error response is enabled. SERR# is also driven, in the same cycle as PERR#, but only in PCI-X mode, only with SERR# reporting enabled, and only while data-parity recovery is disabled. Sticky status bits record each event. Every error also raises a DMA error flag and stops the DMA engine by clearing its active flag.

Top module: `pci_rd_parity_resp`

## Requirements
- R1: Parity is even over ad_i[31:0] and cbe_i[3:0] of a phase with phase_vld_i high, and is compared with par_i in the next cycle (the compare cycle). Only a phase with phase_vld_i high can produce an error.
- R2: In conventional mode (pcix_mode_i=0), a detected error with perr_resp_en_i=1 drives perr_no low for exactly one cycle, two cycles after the data phase.
- R3: In PCI-X mode (pcix_mode_i=1), the same pulse occurs three cycles after the data phase.
- R4: With perr_resp_en_i=0, a detected error never drives perr_no or serr_no low.
- R5: The cycle after any cycle in which perr_no is low, mst_perr_o is 1.
- R6: serr_no is low only in a cycle where perr_no is low. It requires PCI-X mode, serr_en_i=1 and dpe_recov_en_i=0, and is never low in conventional mode.
- R7: The cycle after any cycle in which serr_no is low, serr_sts_o is 1.
- R8: Every detected error sets det_perr_o two cycles after the data phase, whatever the enable inputs are.
- R9: Every detected error sets dma_err_o and clears dma_active_o two cycles after the data phase. The clear wins over a dma_start_i in the compare cycle.
- R10: Each status bit stays set until its own clear strobe is high at a clock edge. A set and a clear in the same cycle leave the bit set.
- R11: Errors in back-to-back phases produce separate one-cycle pulses, each at its own delay.
- R12: Reset drives perr_no and serr_no high, clears every status bit and dma_active_o, and discards pending pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Read data lanes |
| cbe_i | input | 4 | Byte-enable lanes |
| par_i | input | 1 | Bus parity bit, valid the cycle after the phase |
| phase_vld_i | input | 1 | Immediate read data phase completes this cycle |
| pcix_mode_i | input | 1 | 1 = PCI-X mode, 0 = conventional |
| perr_resp_en_i | input | 1 | Parity-error response enable |
| serr_en_i | input | 1 | SERR# reporting enable |
| dpe_recov_en_i | input | 1 | Data-parity recovery enable (blocks SERR#) |
| dma_start_i | input | 1 | Sets the DMA active flag |
| clr_mst_perr_i | input | 1 | Clear strobe for mst_perr_o |
| clr_det_perr_i | input | 1 | Clear strobe for det_perr_o |
| clr_serr_sts_i | input | 1 | Clear strobe for serr_sts_o |
| clr_dma_err_i | input | 1 | Clear strobe for dma_err_o |
| perr_no | output | 1 | PERR#, active low |
| serr_no | output | 1 | SERR#, active low |
| mst_perr_o | output | 1 | Sticky: PERR# was driven |
| det_perr_o | output | 1 | Sticky: a data parity error was detected |
| serr_sts_o | output | 1 | Sticky: SERR# was driven |
| dma_err_o | output | 1 | Sticky DMA error flag |
| dma_active_o | output | 1 | DMA engine active flag |

## Verification
Two pairs of events can land on the same clock edge. In the first, an error sets a sticky bit while software pulses that bit's clear. In the second, an error clears the DMA active flag while a DMA start tries to set it. The bench provokes both by raising the clear strobe, or dma_start_i, in the compare cycle of a corrupted phase. It then reads the status ports once the pulse has passed: det_perr_o must still be 1, dma_active_o must be 0 and dma_err_o must be 1. A separate clear-only cycle then confirms that the strobes do work.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = 4;

  typedef struct packed {
    logic perr;
    logic serr;
  } err_fire_t;
endpackage

// File: rtl/rd_par_check.sv
module rd_par_check #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_i,
  input  logic              vld_i,
  input  logic              par_i,
  output logic              err_o
);
  logic lane_par_q;
  logic vld_q;

  // keep only the folded parity bit, not the full lanes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_par_q <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      lane_par_q <= ^{ad_i, cbe_i};
      vld_q      <= vld_i;
    end
  end

  assign err_o = vld_q & (lane_par_q ^ par_i);

  p_idle_no_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vld_i) |-> !err_o);
endmodule

// File: rtl/err_delay_line.sv
module err_delay_line #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/par_err_status.sv
module par_err_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic perr_i,
  input  logic serr_i,
  input  logic dma_start_i,
  input  logic clr_mst_perr_i,
  input  logic clr_det_perr_i,
  input  logic clr_serr_sts_i,
  input  logic clr_dma_err_i,
  output logic mst_perr_o,
  output logic det_perr_o,
  output logic serr_sts_o,
  output logic dma_err_o,
  output logic dma_active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_perr_o   <= 1'b0;
      det_perr_o   <= 1'b0;
      serr_sts_o   <= 1'b0;
      dma_err_o    <= 1'b0;
      dma_active_o <= 1'b0;
    end else begin
      // set has priority over clear
      mst_perr_o   <= perr_i | (mst_perr_o & ~clr_mst_perr_i);
      det_perr_o   <= det_i  | (det_perr_o & ~clr_det_perr_i);
      serr_sts_o   <= serr_i | (serr_sts_o & ~clr_serr_sts_i);
      dma_err_o    <= det_i  | (dma_err_o  & ~clr_dma_err_i);
      dma_active_o <= ~det_i & (dma_active_o | dma_start_i);
    end
  end

  p_mst_perr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_i |=> mst_perr_o);
  p_serr_sts_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_i |=> serr_sts_o);
  p_det_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |=> det_perr_o);
  p_dma_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |=> (dma_err_o && !dma_active_o));
endmodule

// File: rtl/pci_rd_parity_resp.sv
module pci_rd_parity_resp
  import pci_par_pkg::*;
#(
  parameter int unsigned CONV_DLY = 2,
  parameter int unsigned PCIX_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_i,
  input  logic              par_i,
  input  logic              phase_vld_i,
  input  logic              pcix_mode_i,
  input  logic              perr_resp_en_i,
  input  logic              serr_en_i,
  input  logic              dpe_recov_en_i,
  input  logic              dma_start_i,
  input  logic              clr_mst_perr_i,
  input  logic              clr_det_perr_i,
  input  logic              clr_serr_sts_i,
  input  logic              clr_dma_err_i,
  output logic              perr_no,
  output logic              serr_no,
  output logic              mst_perr_o,
  output logic              det_perr_o,
  output logic              serr_sts_o,
  output logic              dma_err_o,
  output logic              dma_active_o
);
  // compare cycle is one clock after the phase
  localparam int unsigned CONV_STG = CONV_DLY - 1;
  localparam int unsigned PCIX_STG = PCIX_DLY - 1;

  logic      err_det;
  logic      conv_fire, conv_out;
  err_fire_t pcix_fire, pcix_out;
  logic      perr_act, serr_act;

  rd_par_check #(.DATA_W(DATA_W), .BE_W(BE_W)) u_check (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ad_i  (ad_i),
    .cbe_i (cbe_i),
    .vld_i (phase_vld_i),
    .par_i (par_i),
    .err_o (err_det)
  );

  assign conv_fire      = err_det & ~pcix_mode_i & perr_resp_en_i;
  assign pcix_fire.perr = err_det &  pcix_mode_i & perr_resp_en_i;
  assign pcix_fire.serr = pcix_fire.perr & serr_en_i & ~dpe_recov_en_i;

  err_delay_line #(.WIDTH(1), .DEPTH(CONV_STG)) u_conv_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (conv_fire),
    .q_o   (conv_out)
  );

  err_delay_line #(.WIDTH($bits(err_fire_t)), .DEPTH(PCIX_STG)) u_pcix_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pcix_fire),
    .q_o   (pcix_out)
  );

  assign perr_act = conv_out | pcix_out.perr;
  assign serr_act = pcix_out.serr;
  assign perr_no  = ~perr_act;
  assign serr_no  = ~serr_act;

  par_err_status u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .det_i         (err_det),
    .perr_i        (perr_act),
    .serr_i        (serr_act),
    .dma_start_i   (dma_start_i),
    .clr_mst_perr_i(clr_mst_perr_i),
    .clr_det_perr_i(clr_det_perr_i),
    .clr_serr_sts_i(clr_serr_sts_i),
    .clr_dma_err_i (clr_dma_err_i),
    .mst_perr_o    (mst_perr_o),
    .det_perr_o    (det_perr_o),
    .serr_sts_o    (serr_sts_o),
    .dma_err_o     (dma_err_o),
    .dma_active_o  (dma_active_o)
  );

  p_serr_with_perr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> !perr_no);
  p_no_perr_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_det && !perr_resp_en_i) |=> !(conv_out && pcix_out.perr == 1'b0 && $past(!pcix_mode_i)));
endmodule

// File: tb/pci_rd_parity_resp_test.sv
module pci_rd_parity_resp_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        par = 1'b0, vld = 1'b0, pcix = 1'b0, pen = 1'b0, sen = 1'b0, rec = 1'b0;
  logic        dstart = 1'b0, c_mst = 1'b0, c_det = 1'b0, c_serr = 1'b0, c_dma = 1'b0;
  logic        perr_n, serr_n, mst, det, serr_s, dma_err, dma_act;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  pci_rd_parity_resp uut (
    .clk_i(clk), .rst_ni(rst_ni), .ad_i(ad), .cbe_i(cbe), .par_i(par),
    .phase_vld_i(vld), .pcix_mode_i(pcix), .perr_resp_en_i(pen),
    .serr_en_i(sen), .dpe_recov_en_i(rec), .dma_start_i(dstart),
    .clr_mst_perr_i(c_mst), .clr_det_perr_i(c_det), .clr_serr_sts_i(c_serr),
    .clr_dma_err_i(c_dma), .perr_no(perr_n), .serr_no(serr_n),
    .mst_perr_o(mst), .det_perr_o(det), .serr_sts_o(serr_s),
    .dma_err_o(dma_err), .dma_active_o(dma_act)
  );

  typedef struct packed {
    logic        pcix, pen, sen, rec, bad;
    logic [31:0] ad;
    logic [3:0]  be;
    logic [2:0]  perr_cyc;  // cycle after phase where PERR# is low, 0 = none
    logic [2:0]  serr_cyc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'hF, 3'd0, 3'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h1234_5678, 4'h3, 3'd2, 3'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0001, 4'h0, 3'd3, 3'd3},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'hA, 3'd3, 3'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 4'h1, 3'd3, 3'd0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h5A5A_A5A5, 4'hC, 3'd0, 3'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hCAFE_0042, 4'h7, 3'd0, 3'd0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0F0F_0F0F, 4'h9, 3'd0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    c_mst = 1; c_det = 1; c_serr = 1; c_dma = 1;
    step();
    c_mst = 0; c_det = 0; c_serr = 0; c_dma = 0;
  endtask

  task automatic arm_dma();
    dstart = 1; step(); dstart = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first_p, first_s, n_p, n_s;
    step();
    // R12 reset state
    chk("R12 perr_n in reset", perr_n, 1);
    chk("R12 serr_n in reset", serr_n, 1);
    chk("R12 status in reset", {mst, det, serr_s, dma_err, dma_act}, 0);
    rst_ni = 1; step();

    foreach (VECS[i]) begin
      clear_all(); arm_dma();
      pcix = VECS[i].pcix; pen = VECS[i].pen; sen = VECS[i].sen; rec = VECS[i].rec;
      ad = VECS[i].ad; cbe = VECS[i].be; vld = 1;
      step();
      vld = 0; par = ^{VECS[i].ad, VECS[i].be} ^ VECS[i].bad;
      first_p = 0; first_s = 0; n_p = 0; n_s = 0;
      for (int k = 1; k <= 5; k++) begin
        if (!perr_n) begin n_p++; if (first_p == 0) first_p = k; end
        if (!serr_n) begin n_s++; if (first_s == 0) first_s = k; end
        if (k == 2) begin
          chk($sformatf("R8 det at cycle 2 vec %0d", i), det, VECS[i].bad);
          chk($sformatf("R9 dma_err at cycle 2 vec %0d", i), dma_err, VECS[i].bad);
        end
        step();
      end
      chk($sformatf("R2 R3 R4 perr cycle vec %0d", i), first_p, VECS[i].perr_cyc);
      chk($sformatf("R2 perr width vec %0d", i), n_p, VECS[i].perr_cyc != 0);
      chk($sformatf("R6 serr cycle vec %0d", i), first_s, VECS[i].serr_cyc);
      chk($sformatf("R5 mst vec %0d", i), mst, VECS[i].perr_cyc != 0);
      chk($sformatf("R7 serr_sts vec %0d", i), serr_s, VECS[i].serr_cyc != 0);
      chk($sformatf("R1 R8 det vec %0d", i), det, VECS[i].bad);
      chk($sformatf("R9 dma_active vec %0d", i), dma_act, !VECS[i].bad);
    end

    // R11 back-to-back PCI-X errors
    clear_all();
    pcix = 1; pen = 1; sen = 1; rec = 0;
    ad = 32'h1111_0000; cbe = 4'h5; vld = 1; step();
    par = ~^{32'h1111_0000, 4'h5};
    ad = 32'h0000_2222; cbe = 4'hE; step();
    vld = 0; par = ~^{32'h0000_2222, 4'hE};
    step();
    chk("R11 first pulse cycle 3", perr_n, 0);
    chk("R11 serr first pulse", serr_n, 0);
    step();
    chk("R11 second pulse cycle 4", perr_n, 0);
    step();
    chk("R11 pulses ended", perr_n, 1);

    // R10 set beats clear; R9 abort beats start
    clear_all();
    pcix = 0; ad = 32'hABCD_0123; cbe = 4'h6; vld = 1; step();
    vld = 0; par = ~^{32'hABCD_0123, 4'h6};
    c_det = 1; dstart = 1; step();
    c_det = 0; dstart = 0;
    repeat (3) step();
    chk("R10 det kept on set+clear", det, 1);
    chk("R9 active cleared over start", dma_act, 0);
    chk("R9 dma_err set", dma_err, 1);
    c_det = 1; step(); c_det = 0;
    chk("R10 det cleared", det, 0);
    chk("R10 dma_err unaffected by det clear", dma_err, 1);
    c_dma = 1; step(); c_dma = 0;
    chk("R10 dma_err cleared", dma_err, 0);
    chk("R10 mst still set", mst, 1);

    // R12 reset flushes pending PCI-X pulse
    clear_all();
    pcix = 1; ad = 32'h7777_7777; cbe = 4'h2; vld = 1; step();
    vld = 0; par = ~^{32'h7777_7777, 4'h2}; step();
    rst_ni = 0; #1;
    chk("R12 status cleared by reset", {mst, det, serr_s, dma_err, dma_act}, 0);
    step(); rst_ni = 1;
    n_p = 0;
    for (int k = 0; k < 4; k++) begin
      if (!perr_n || !serr_n) n_p++;
      step();
    end
    chk("R12 pending pulse flushed", n_p, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule